// File: doc/BRIEF.md
# Command Queue Ring Pointer Controller

This block sits on the device side of a circular command queue kept in host memory. Software programs the queue's 64-bit base address and its entry count, writes a producer index (the tail), and then signals new work with a doorbell write. The block compares its own consumer index (the head) against the tail. It issues one fetch request per pending 64-byte entry to a fetch engine over a request/acknowledge handshake. The head moves forward only when the engine acknowledges a fetch.

Software sees eight 32-bit words through a simple register port. Writes take effect on the clock edge. Reads are combinational from the address. Software can stop new fetches without losing the doorbell (pause), or throw away all queued work at once (abort). A status word reports whether the ring is empty or full, how many entries are pending, and whether the programmed size is illegal. An illegal size blocks all fetching.

Top module: `cmdq_ring_ctrl`

## Requirements
- R1: The register words sit at these word addresses: 0 base low, 1 base high, 2 size, 3 head, 4 tail, 5 control, 6 status, 7 doorbell. After reset every stored register is zero, no fetch request is raised, and status reads 0x0000000A (empty and error).
- R2: The size field (bits [15:0]) is legal only when it is a power of two from 1 to 4096. Otherwise status bit 3 (error) is set. Any write to the size word clears head, tail and the doorbell state.
- R3: Bits [11:0] of the base low word always read zero, because the base is 4 KB aligned. The base high word stores all 32 bits.
- R4: A tail write is stored modulo the ring size. The head word is read-only, and writes to it change nothing.
- R5: No fetch starts until the doorbell word is written, whatever value is written. The doorbell reads as zero.
- R6: A fetch request presents address base + head × 64 and holds it stable until acknowledged. On acknowledge the head advances by one modulo the size and the request drops. Only one request is outstanding at a time.
- R7: After a doorbell, fetches continue entry by entry, wrapping past the last index, until head equals tail.
- R8: Control bit 1 (pause) blocks new requests. A doorbell seen during the pause is kept, and fetching resumes when the pause is cleared.
- R9: Writing control bit 2 (abort) sets head to tail, withdraws any open request, and drops the doorbell state. The bit reads back as zero one cycle later.
- R10: New requests are issued only while control bit 0 (enable) is set and the size is legal. A doorbell received while disabled is kept.
- R11: Status word bits are: [0] active (enabled, not paused, legal size), [1] empty (head equals tail), [2] full ((tail+1) mod size equals head), [3] error, and [15:8] pending count ((tail−head) mod size, saturating at 255).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| fetch_ack | input | 1 | Fetch engine accepts the open request |
| fetch_req | output | 1 | Fetch request for the entry at the head |
| fetch_addr | output | 64 | Host address of the entry to fetch |

## Verification
The bench probes several boundary cases:
- The wrap from the last index back to zero. A head that forgets the modulo produces an address past the ring.
- Pending counts above 255. A counter that does not saturate shows only the low byte.
- A doorbell that arrives while the ring is paused or disabled. A design that drops it never resumes fetching.
- An abort with a request in flight. A design that keeps the request, or leaves the head behind the tail, would fetch discarded work.
- Illegal sizes (6, 8192). These must raise the error bit and block every request.

// File: rtl/cmdq_pkg.sv
// Shared register addresses and field layouts for the command queue
// ring pointer controller.
package cmdq_pkg;

    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        RA_BASE_LO = 3'd0,
        RA_BASE_HI = 3'd1,
        RA_SIZE    = 3'd2,
        RA_HEAD    = 3'd3,
        RA_TAIL    = 3'd4,
        RA_CTRL    = 3'd5,
        RA_STATUS  = 3'd6,
        RA_BELL    = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic abort;
        logic pause;
        logic enable;
    } ctrl_t;

    typedef struct packed {
        logic [7:0] pending;
        logic [3:0] rsvd;
        logic       error;
        logic       full;
        logic       empty;
        logic       active;
    } status_t;

endpackage

// File: rtl/cmdq_regfile.sv
// Register file of the ring controller. It holds base, size, tail and
// control, checks that the size is legal, derives the index mask, and
// serves combinational reads. Assumes one register access per cycle and
// a size field no wider than IDX_W bits.
module cmdq_regfile
    import cmdq_pkg::*;
#(
    parameter int          IDX_W           = 16,
    parameter int unsigned MAX_ENTRIES     = 4096,
    parameter int          BASE_ALIGN_BITS = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic [IDX_W-1:0]     head_i,
    input  status_t              status_i,
    output logic [63:0]          base_o,
    output logic [IDX_W-1:0]     tail_o,
    output logic [IDX_W-1:0]     mask_o,
    output logic                 size_err_o,
    output ctrl_t                ctrl_o,
    output logic                 bell_o,
    output logic                 size_wr_o
);

    localparam int LO_KEEP = 32 - BASE_ALIGN_BITS;

    logic [LO_KEEP-1:0] base_lo_q;
    logic [31:0]        base_hi_q;
    logic [IDX_W-1:0]   size_q;
    logic [IDX_W-1:0]   tail_q;
    logic               en_q;
    logic               pause_q;
    logic               abort_q;
    reg_addr_e          addr_e;
    logic               size_ok;

    assign addr_e = reg_addr_e'(reg_addr);

    // Size legality: nonzero, single bit set, within the entry limit.
    always_comb begin
        size_ok = (size_q != '0) && ((size_q & (size_q - 1'b1)) == '0)
                  && (32'(size_q) <= MAX_ENTRIES);
        mask_o     = size_ok ? (size_q - 1'b1) : '1;
        size_err_o = !size_ok;
    end

    // Write-side strobes seen by the pointer sequencer.
    always_comb begin
        bell_o    = reg_wr && (addr_e == RA_BELL);
        size_wr_o = reg_wr && (addr_e == RA_SIZE);
    end

    // Register storage and the one-cycle abort pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_lo_q <= '0;
            base_hi_q <= '0;
            size_q    <= '0;
            tail_q    <= '0;
            en_q      <= 1'b0;
            pause_q   <= 1'b0;
            abort_q   <= 1'b0;
        end else begin
            abort_q <= 1'b0;
            if (reg_wr) begin
                case (addr_e)
                    RA_BASE_LO: base_lo_q <= reg_wdata[31:BASE_ALIGN_BITS];
                    RA_BASE_HI: base_hi_q <= reg_wdata;
                    RA_SIZE: begin
                        size_q <= reg_wdata[IDX_W-1:0];
                        tail_q <= '0;
                    end
                    RA_TAIL:    tail_q <= reg_wdata[IDX_W-1:0] & mask_o;
                    RA_CTRL: begin
                        en_q    <= reg_wdata[0];
                        pause_q <= reg_wdata[1];
                        abort_q <= reg_wdata[2];
                    end
                    default: ;
                endcase
            end
        end
    end

    assign base_o = {base_hi_q, base_lo_q, {BASE_ALIGN_BITS{1'b0}}};
    assign tail_o = tail_q;
    assign ctrl_o = '{abort: abort_q, pause: pause_q, enable: en_q};

    // Read multiplexer; write-only and reserved fields return zero.
    always_comb begin
        case (addr_e)
            RA_BASE_LO: reg_rdata = {base_lo_q, {BASE_ALIGN_BITS{1'b0}}};
            RA_BASE_HI: reg_rdata = base_hi_q;
            RA_SIZE:    reg_rdata = 32'(size_q);
            RA_HEAD:    reg_rdata = 32'(head_i);
            RA_TAIL:    reg_rdata = 32'(tail_q);
            RA_CTRL:    reg_rdata = {29'd0, abort_q, pause_q, en_q};
            RA_STATUS:  reg_rdata = {16'd0, status_i};
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cmdq_fetch_seq.sv
// Head pointer and fetch sequencer. After a doorbell it raises one
// request per pending entry, holds it until acknowledged, then moves
// the head. Assumes the fetch engine keeps fetch_ack low when no
// request is open.
module cmdq_fetch_seq
    import cmdq_pkg::*;
#(
    parameter int IDX_W       = 16,
    parameter int ENTRY_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [63:0]       base_i,
    input  logic [IDX_W-1:0]  tail_i,
    input  logic [IDX_W-1:0]  mask_i,
    input  logic              size_err_i,
    input  ctrl_t             ctrl_i,
    input  logic              bell_i,
    input  logic              size_wr_i,
    input  logic              fetch_ack,
    output logic [IDX_W-1:0]  head_o,
    output logic              fetch_req,
    output logic [63:0]       fetch_addr
);

    localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);

    logic [IDX_W-1:0] head_q;
    logic             req_q;
    logic             bell_q;
    logic             can_issue;

    // A new request needs permission, a doorbell and pending work.
    always_comb begin
        can_issue = ctrl_i.enable && !ctrl_i.pause && !ctrl_i.abort
                    && !size_err_i && bell_q && (head_q != tail_i) && !req_q;
    end

    // Head, request and doorbell state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            req_q  <= 1'b0;
            bell_q <= 1'b0;
        end else if (size_wr_i) begin
            head_q <= '0;
            req_q  <= 1'b0;
            bell_q <= 1'b0;
        end else if (ctrl_i.abort) begin
            head_q <= tail_i;
            req_q  <= 1'b0;
            bell_q <= 1'b0;
        end else begin
            if (req_q && fetch_ack) begin
                head_q <= (head_q + 1'b1) & mask_i;
                req_q  <= 1'b0;
            end else if (can_issue) begin
                req_q <= 1'b1;
            end
            if (bell_i) begin
                bell_q <= 1'b1;
            end else if (!req_q && (head_q == tail_i)) begin
                bell_q <= 1'b0;
            end
        end
    end

    assign head_o     = head_q;
    assign fetch_req  = req_q;
    assign fetch_addr = base_i + ({{(64-IDX_W){1'b0}}, head_q} << ENTRY_SHIFT);

endmodule

// File: rtl/cmdq_status_gen.sv
// Status word builder: empty, full, saturating pending count, active
// and error flags. Purely combinational; assumes head and tail already
// lie within the mask.
module cmdq_status_gen
    import cmdq_pkg::*;
#(
    parameter int IDX_W  = 16,
    parameter int PEND_W = 8
) (
    input  logic [IDX_W-1:0] head_i,
    input  logic [IDX_W-1:0] tail_i,
    input  logic [IDX_W-1:0] mask_i,
    input  logic             size_err_i,
    input  ctrl_t            ctrl_i,
    output status_t          status_o
);

    localparam logic [IDX_W-1:0] PEND_MAX = IDX_W'((1 << PEND_W) - 1);

    logic [IDX_W-1:0] diff;

    // Flag and counter derivation.
    always_comb begin
        diff                = (tail_i - head_i) & mask_i;
        status_o.rsvd       = '0;
        status_o.error      = size_err_i;
        status_o.empty      = (head_i == tail_i);
        status_o.full       = (((tail_i + 1'b1) & mask_i) == head_i);
        status_o.active     = ctrl_i.enable && !ctrl_i.pause && !size_err_i;
        status_o.pending    = (diff > PEND_MAX) ? PEND_MAX[7:0] : diff[7:0];
    end

endmodule

// File: rtl/cmdq_ring_ctrl.sv
// Top of the command queue ring pointer controller. It ties together the
// register file, the fetch sequencer and the status builder. The
// register port is synchronous for writes and combinational for reads.
module cmdq_ring_ctrl
    import cmdq_pkg::*;
#(
    parameter int          IDX_W           = 16,
    parameter int unsigned MAX_ENTRIES     = 4096,
    parameter int          ENTRY_BYTES     = 64,
    parameter int          BASE_ALIGN_BITS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              fetch_ack,
    output logic              fetch_req,
    output logic [63:0]       fetch_addr
);

    logic [63:0]      base_w;
    logic [IDX_W-1:0] head_w;
    logic [IDX_W-1:0] tail_w;
    logic [IDX_W-1:0] mask_w;
    logic             size_err_w;
    logic             bell_w;
    logic             size_wr_w;
    ctrl_t            ctrl_w;
    status_t          status_w;
    logic             abort_w;
    logic             pause_w;
    logic             enable_w;

    assign abort_w  = ctrl_w.abort;
    assign pause_w  = ctrl_w.pause;
    assign enable_w = ctrl_w.enable;

    cmdq_regfile #(
        .IDX_W(IDX_W), .MAX_ENTRIES(MAX_ENTRIES), .BASE_ALIGN_BITS(BASE_ALIGN_BITS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .head_i(head_w),
        .status_i(status_w), .base_o(base_w), .tail_o(tail_w), .mask_o(mask_w),
        .size_err_o(size_err_w), .ctrl_o(ctrl_w), .bell_o(bell_w),
        .size_wr_o(size_wr_w)
    );

    cmdq_fetch_seq #(.IDX_W(IDX_W), .ENTRY_BYTES(ENTRY_BYTES)) u_seq (
        .clk(clk), .rst_n(rst_n), .base_i(base_w), .tail_i(tail_w),
        .mask_i(mask_w), .size_err_i(size_err_w), .ctrl_i(ctrl_w),
        .bell_i(bell_w), .size_wr_i(size_wr_w), .fetch_ack(fetch_ack),
        .head_o(head_w), .fetch_req(fetch_req), .fetch_addr(fetch_addr)
    );

    cmdq_status_gen #(.IDX_W(IDX_W), .PEND_W(8)) u_stat (
        .head_i(head_w), .tail_i(tail_w), .mask_i(mask_w),
        .size_err_i(size_err_w), .ctrl_i(ctrl_w), .status_o(status_w)
    );

endmodule

// File: rtl/cmdq_ring_ctrl_chk.sv
// Protocol checker for the ring controller, bound into the top module.
module cmdq_ring_ctrl_chk #(
    parameter int IDX_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fetch_req,
    input logic             fetch_ack,
    input logic [63:0]      fetch_addr,
    input logic [IDX_W-1:0] head,
    input logic [IDX_W-1:0] tail,
    input logic [IDX_W-1:0] mask,
    input logic             abort,
    input logic             pause,
    input logic             enable,
    input logic             size_err,
    input logic             size_wr
);

    // R6: an unacknowledged request stays up with a stable address.
    a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && !fetch_ack && !abort && !size_wr
        |=> fetch_req && $stable(fetch_addr));

    // R6: acknowledge moves head by one and closes the request.
    a_r6_head_step: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && fetch_ack && !abort && !size_wr
        |=> !fetch_req && (head == (($past(head) + 1'b1) & $past(mask))));

    // R9: abort lands head on tail and withdraws the request.
    a_r9_abort_sync: assert property (@(posedge clk) disable iff (!rst_n)
        abort && !size_wr |=> (head == $past(tail)) && !fetch_req);

    // R8: no new request while paused.
    a_r8_pause_block: assert property (@(posedge clk) disable iff (!rst_n)
        pause && !fetch_req |=> !fetch_req);

    // R10: no new request while disabled or with an illegal size.
    a_r10_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (size_err || !enable) && !fetch_req |=> !fetch_req);

endmodule

bind cmdq_ring_ctrl cmdq_ring_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_ack(fetch_ack),
    .fetch_addr(fetch_addr), .head(head_w), .tail(tail_w), .mask(mask_w),
    .abort(abort_w), .pause(pause_w), .enable(enable_w),
    .size_err(size_err_w), .size_wr(size_wr_w)
);

// File: tb/cmdq_ring_ctrl_test.sv
`timescale 1ns/1ps
module cmdq_ring_ctrl_test;

    localparam logic [2:0] A_BLO = 3'd0, A_BHI = 3'd1, A_SIZE = 3'd2, A_HEAD = 3'd3,
                           A_TAIL = 3'd4, A_CTRL = 3'd5, A_STAT = 3'd6, A_BELL = 3'd7;
    localparam logic [63:0] BASE = 64'h0000_000A_1234_5000;

    typedef struct packed {
        logic        wr;
        logic [2:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{1'b0, A_STAT, 32'h0, 32'h0000_000A},   // R1 reset status
        '{1'b0, A_SIZE, 32'h0, 32'h0},           // R1
        '{1'b0, A_CTRL, 32'h0, 32'h0},           // R1
        '{1'b1, A_SIZE, 32'd6, 32'h0},
        '{1'b0, A_STAT, 32'h0, 32'h0000_000A},   // R2 not power of two
        '{1'b1, A_SIZE, 32'd8192, 32'h0},
        '{1'b0, A_STAT, 32'h0, 32'h0000_000A},   // R2 above limit
        '{1'b1, A_SIZE, 32'd4096, 32'h0},
        '{1'b0, A_STAT, 32'h0, 32'h0000_0002},   // R2 limit is legal
        '{1'b1, A_SIZE, 32'd512, 32'h0},
        '{1'b1, A_TAIL, 32'd300, 32'h0},
        '{1'b0, A_STAT, 32'h0, 32'h0000_FF00},   // R11 saturation
        '{1'b1, A_SIZE, 32'd8, 32'h0},
        '{1'b0, A_TAIL, 32'h0, 32'h0},           // R2 size write clears tail
        '{1'b1, A_TAIL, 32'd11, 32'h0},
        '{1'b0, A_TAIL, 32'h0, 32'd3},           // R4 modulo
        '{1'b0, A_STAT, 32'h0, 32'h0000_0300},   // R11 pending 3
        '{1'b1, A_HEAD, 32'd5, 32'h0},
        '{1'b0, A_HEAD, 32'h0, 32'h0},           // R4 head read-only
        '{1'b1, A_TAIL, 32'd7, 32'h0},
        '{1'b0, A_STAT, 32'h0, 32'h0000_0704},   // R11 full
        '{1'b1, A_BLO, 32'h1234_5FFF, 32'h0},
        '{1'b0, A_BLO, 32'h0, 32'h1234_5000},    // R3 alignment
        '{1'b1, A_BHI, 32'h0000_000A, 32'h0},
        '{1'b0, A_BHI, 32'h0, 32'h0000_000A},    // R3
        '{1'b0, A_BELL, 32'h0, 32'h0}            // R5 doorbell reads zero
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fetch_ack = 1'b0;
    logic        fetch_req;
    logic [63:0] fetch_addr;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    cmdq_ring_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_ack(fetch_ack),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic idle_no_req(input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(tag, 64'(fetch_req), 64'd0);
        end
    endtask

    task automatic wait_req(input string tag);
        int n = 0;
        @(negedge clk);
        while (!fetch_req && n < 50) begin
            @(negedge clk);
            n++;
        end
        check({tag, " request raised"}, 64'(fetch_req), 64'd1);
    endtask

    // Serve one fetch at the expected index and check the handshake.
    task automatic serve(input string tag, input int idx);
        wait_req(tag);
        check({tag, " address"}, fetch_addr, BASE + 64'(idx) * 64);
        @(negedge clk);
        check({tag, " held"}, 64'(fetch_req), 64'd1);
        fetch_ack = 1'b1;
        @(negedge clk);
        fetch_ack = 1'b0;
        check({tag, " dropped after ack"}, 64'(fetch_req), 64'd0);
    endtask

    // Watchdog: a hung run is counted as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog got=%0d exp<=20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 no request after reset", 64'(fetch_req), 64'd0);

        // Table walk over register behaviour.
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) wr(VECS[i].addr, VECS[i].data);
            else rd($sformatf("table vector %0d", i), VECS[i].addr, VECS[i].exp);
        end

        // R5: enabled but no doorbell, nothing fetched.
        wr(A_CTRL, 32'h1);
        idle_no_req("R5 waits for doorbell", 6);
        rd("R5 head unchanged", A_HEAD, 32'd0);

        // R6/R7: doorbell drains seven entries.
        wr(A_BELL, 32'hDEAD_0000);
        for (int k = 0; k < 7; k++) serve($sformatf("R6 R7 entry %0d", k), k);
        idle_no_req("R7 stops at tail", 3);
        rd("R7 head reached tail", A_HEAD, 32'd7);
        rd("R11 empty active", A_STAT, 32'h0000_0003);

        // R8: pause keeps the doorbell; wrap from 7 to 0 after resume.
        wr(A_CTRL, 32'h3);
        wr(A_TAIL, 32'd2);
        wr(A_BELL, 32'h0);
        idle_no_req("R8 paused", 6);
        rd("R8 status while paused", A_STAT, 32'h0000_0300);
        rd("R8 head held", A_HEAD, 32'd7);
        wr(A_CTRL, 32'h1);
        serve("R8 R7 wrap idx7", 7);
        serve("R8 R7 wrap idx0", 0);
        serve("R8 R7 wrap idx1", 1);
        rd("R7 head after wrap", A_HEAD, 32'd2);

        // R9: abort with a request open.
        wr(A_TAIL, 32'd6);
        wr(A_BELL, 32'h1);
        wait_req("R9 before abort");
        wr(A_CTRL, 32'h5);
        @(negedge clk);
        check("R9 request withdrawn", 64'(fetch_req), 64'd0);
        rd("R9 head equals tail", A_HEAD, 32'd6);
        rd("R9 abort bit self-clears", A_CTRL, 32'h1);
        rd("R9 ring empty", A_STAT, 32'h0000_0003);
        idle_no_req("R9 no refetch", 4);

        // R10: illegal size blocks fetching.
        wr(A_SIZE, 32'd6);
        wr(A_TAIL, 32'd5);
        wr(A_BELL, 32'h0);
        idle_no_req("R10 size error blocks", 6);
        // R10: disabled keeps doorbell.
        wr(A_CTRL, 32'h0);
        wr(A_SIZE, 32'd8);
        wr(A_TAIL, 32'd3);
        wr(A_BELL, 32'h0);
        idle_no_req("R10 disabled blocks", 6);
        wr(A_CTRL, 32'h1);
        serve("R10 resume idx0", 0);
        serve("R10 resume idx1", 1);
        serve("R10 resume idx2", 2);

        // R1: reset in the middle of a fetch.
        wr(A_TAIL, 32'd5);
        wr(A_BELL, 32'h0);
        wait_req("R1 before reset");
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R1 request cleared", 64'(fetch_req), 64'd0);
        rd("R1 size cleared", A_SIZE, 32'd0);
        rd("R1 ctrl cleared", A_CTRL, 32'd0);
        rd("R1 head cleared", A_HEAD, 32'd0);
        rd("R1 base cleared", A_BLO, 32'd0);
        rd("R1 status after reset", A_STAT, 32'h0000_000A);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule